// File: doc/BRIEF.md
# RV32IM Instruction Legality Checker

This block examines one 32-bit instruction word and decides whether it belongs to the 32-bit base integer set with the multiply/divide extension. For a legal word it also reports which of ten instruction classes the word falls into. The class is given as a one-hot vector. Every opcode, funct3 and funct7 field is matched exactly, with no loose don't-care bits. Words that only a 64-bit core may execute, reserved encodings and compressed encodings are therefore all reported as illegal.

A front end places the checker beside its main decoder. It raises `inValid` together with a word and uses the flagged result to raise an illegal-instruction trap instead of executing the word. By default one register stage sits between the decode logic and the outputs. `outValid` follows `inValid` by one cycle, and the outputs hold their last value while no word is offered. Setting `REG_OUT` to 0 turns the block into a purely combinational path.

Top module: `rvLegalityCheck`

## Requirements
- R1: A word whose bits [1:0] are not 2'b11 (a compressed encoding) is flagged illegal.
- R2: The class output is one-hot for a legal word and all zero for an illegal one. The bit positions are: 0 load, 1 store, 2 branch, 3 jump (JAL, JALR), 4 ALU-immediate, 5 ALU-register, 6 multiply/divide, 7 upper-immediate (LUI, AUIPC), 8 system, 9 fence.
- R3: A load (opcode 0000011) is legal only for funct3 000, 001, 010, 100 or 101. Funct3 011, 110 (the 64-bit unsigned word load) and 111 are illegal.
- R4: A store (opcode 0100011) is legal only for funct3 000, 001 or 010.
- R5: In the ALU-immediate group (opcode 0010011), funct3 001 needs bits [31:25] equal to 0000000, and funct3 101 needs 0000000 or 0100000. A set bit 25 therefore makes a shift illegal. The other funct3 values are legal whatever the upper bits hold.
- R6: In the ALU-register group (opcode 0110011), funct7 0000000 is legal for every funct3, and funct7 0100000 only for funct3 000 or 101. Every funct7 other than these and 0000001 is illegal.
- R7: Opcode 0110011 with funct7 0000001 is legal for all eight funct3 values and is reported in the multiply/divide class.
- R8: Every opcode not named in R3 to R10 is illegal. This includes the 64-bit word-arithmetic opcodes 0011011 and 0111011.
- R9: A branch (1100011) is illegal for funct3 010 or 011. JALR (1100111) is legal only with funct3 000. JAL (1101111), LUI (0110111) and AUIPC (0010111) are always legal.
- R10: For opcode 1110011, funct3 000 is legal only as the exact words 32'h00000073 and 32'h00100073, funct3 100 is illegal, and the other funct3 values are legal. Opcode 0001111 is legal only with funct3 000.
- R11: With `REG_OUT`=1, the result for a word offered with `inValid` high appears one cycle later, with `outValid` high. While `inValid` is low, `outValid` drops and the result holds its value. Reset clears `outValid`, `illegal` and the class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | A word is offered this cycle |
| instr | input | 32 | Instruction word under test |
| outValid | output | 1 | The result belongs to a word offered one cycle earlier |
| illegal | output | 1 | The word is not a legal RV32IM instruction |
| instrClass | output | 10 | One-hot class of a legal word; zero when illegal |

## Verification
The result for a word is due one cycle after it is offered. The rising edge that follows the offer captures the decision into the output stage. The bench drives every word on a falling edge and samples on the next falling edge, so exactly one capturing edge lies between stimulus and check. The hold behaviour is checked with the same spacing: `inValid` is dropped and the word is changed, and the outputs are then expected to be unchanged one falling edge later.

// File: rtl/rvl_pkg.sv
package rvl_pkg;

  localparam int INSTR_W = 32;
  localparam int OPC_W   = 7;
  localparam int CLASS_W = 10;

  // class bit positions (part of the external contract)
  localparam int CLS_LOAD   = 0;
  localparam int CLS_STORE  = 1;
  localparam int CLS_BRANCH = 2;
  localparam int CLS_JUMP   = 3;
  localparam int CLS_ALUIMM = 4;
  localparam int CLS_ALUREG = 5;
  localparam int CLS_MULDIV = 6;
  localparam int CLS_UPPER  = 7;
  localparam int CLS_SYSTEM = 8;
  localparam int CLS_FENCE  = 9;

  localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
  localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
  localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
  localparam logic [OPC_W-1:0] OPC_JAL    = 7'b1101111;
  localparam logic [OPC_W-1:0] OPC_JALR   = 7'b1100111;
  localparam logic [OPC_W-1:0] OPC_IMM    = 7'b0010011;
  localparam logic [OPC_W-1:0] OPC_REG    = 7'b0110011;
  localparam logic [OPC_W-1:0] OPC_LUI    = 7'b0110111;
  localparam logic [OPC_W-1:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [OPC_W-1:0] OPC_SYSTEM = 7'b1110011;
  localparam logic [OPC_W-1:0] OPC_FENCE  = 7'b0001111;
  localparam logic [OPC_W-1:0] OPC_IMM64  = 7'b0011011;
  localparam logic [OPC_W-1:0] OPC_REG64  = 7'b0111011;

  localparam logic [6:0] F7_BASE = 7'b0000000;
  localparam logic [6:0] F7_ALT  = 7'b0100000;
  localparam logic [6:0] F7_MUL  = 7'b0000001;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic lowOk;
    logic opLoad;
    logic opStore;
    logic opBranch;
    logic opJal;
    logic opJalr;
    logic opImm;
    logic opReg;
    logic opLui;
    logic opAuipc;
    logic opSystem;
    logic opFence;
  } rvlStrobes_t;

endpackage

// File: rtl/rvlControl.sv
module rvlControl
  import rvl_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic             inValid,
  output rvlStrobes_t      strobes
);

  always_comb begin
    strobes         = '0;
    strobes.capture = inValid;
    strobes.lowOk   = (opcode[1:0] == 2'b11);
    unique case (opcode)
      OPC_LOAD:   strobes.opLoad   = 1'b1;
      OPC_STORE:  strobes.opStore  = 1'b1;
      OPC_BRANCH: strobes.opBranch = 1'b1;
      OPC_JAL:    strobes.opJal    = 1'b1;
      OPC_JALR:   strobes.opJalr   = 1'b1;
      OPC_IMM:    strobes.opImm    = 1'b1;
      OPC_REG:    strobes.opReg    = 1'b1;
      OPC_LUI:    strobes.opLui    = 1'b1;
      OPC_AUIPC:  strobes.opAuipc  = 1'b1;
      OPC_SYSTEM: strobes.opSystem = 1'b1;
      OPC_FENCE:  strobes.opFence  = 1'b1;
      default:    ;
    endcase
  end

endmodule

// File: rtl/rvlDatapath.sv
module rvlDatapath
  import rvl_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [INSTR_W-1:0] instr,
  input  rvlStrobes_t        strobes,
  output logic               outValid,
  output logic               illegalOut,
  output logic [CLASS_W-1:0] classOut
);

  logic [2:0] funct3;
  logic [6:0] funct7;
  logic [4:0] rdField;
  logic [4:0] rs1Field;
  logic [4:0] rs2Field;

  assign funct3   = instr[14:12];
  assign funct7   = instr[31:25];
  assign rdField  = instr[11:7];
  assign rs1Field = instr[19:15];
  assign rs2Field = instr[24:20];

  // field legality per group
  logic loadOk, storeOk, branchOk, jalrOk, immOk, regBaseOk, mulOk;
  logic systemOk, fenceOk, envExact;

  always_comb begin
    unique case (funct3)
      3'b000, 3'b001, 3'b010, 3'b100, 3'b101: loadOk = 1'b1;
      default:                                loadOk = 1'b0;
    endcase
  end

  assign storeOk  = (funct3[2] == 1'b0) && (funct3[1:0] != 2'b11);
  assign branchOk = (funct3[2:1] != 2'b01);
  assign jalrOk   = (funct3 == 3'b000);

  always_comb begin
    unique case (funct3)
      3'b001:  immOk = (funct7 == F7_BASE);
      3'b101:  immOk = (funct7 == F7_BASE) || (funct7 == F7_ALT);
      default: immOk = 1'b1;
    endcase
  end

  always_comb begin
    if (funct7 == F7_BASE)     regBaseOk = 1'b1;
    else if (funct7 == F7_ALT) regBaseOk = (funct3 == 3'b000) || (funct3 == 3'b101);
    else                       regBaseOk = 1'b0;
  end

  assign mulOk = (funct7 == F7_MUL);

  // environment call / breakpoint: all non-opcode fields fixed
  assign envExact = (rdField == 5'd0) && (rs1Field == 5'd0) && (funct7 == 7'd0) &&
                    ((rs2Field == 5'd0) || (rs2Field == 5'd1));

  always_comb begin
    unique case (funct3)
      3'b000:  systemOk = envExact;
      3'b100:  systemOk = 1'b0;
      default: systemOk = 1'b1;
    endcase
  end

  assign fenceOk = (funct3 == 3'b000);

  // class vector
  logic [CLASS_W-1:0] classComb;
  logic               illegalComb;

  always_comb begin
    classComb = '0;
    if (strobes.lowOk) begin
      classComb[CLS_LOAD]   = strobes.opLoad   && loadOk;
      classComb[CLS_STORE]  = strobes.opStore  && storeOk;
      classComb[CLS_BRANCH] = strobes.opBranch && branchOk;
      classComb[CLS_JUMP]   = strobes.opJal    || (strobes.opJalr && jalrOk);
      classComb[CLS_ALUIMM] = strobes.opImm    && immOk;
      classComb[CLS_ALUREG] = strobes.opReg    && regBaseOk;
      classComb[CLS_MULDIV] = strobes.opReg    && mulOk;
      classComb[CLS_UPPER]  = strobes.opLui    || strobes.opAuipc;
      classComb[CLS_SYSTEM] = strobes.opSystem && systemOk;
      classComb[CLS_FENCE]  = strobes.opFence  && fenceOk;
    end
  end

  assign illegalComb = (classComb == '0);

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          outValid   <= 1'b0;
          illegalOut <= 1'b0;
          classOut   <= '0;
        end else begin
          outValid <= strobes.capture;
          if (strobes.capture) begin
            illegalOut <= illegalComb;
            classOut   <= classComb;
          end
        end
      end

      p_compressed_r1: assert property (@(posedge clk) disable iff (!rstN)
        strobes.capture && (instr[1:0] != 2'b11) |=> illegalOut);

      p_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
        outValid |-> ($onehot0(classOut) && (illegalOut != (classOut != '0))));

      p_lwu_r3: assert property (@(posedge clk) disable iff (!rstN)
        strobes.capture && (instr[6:0] == OPC_LOAD) && (instr[14:12] == 3'b110)
        |=> illegalOut);

      p_shamt5_r5: assert property (@(posedge clk) disable iff (!rstN)
        strobes.capture && (instr[6:0] == OPC_IMM) && (instr[13:12] == 2'b01) && instr[25]
        |=> illegalOut);

      p_muldiv_r7: assert property (@(posedge clk) disable iff (!rstN)
        strobes.capture && (instr[6:0] == OPC_REG) && (instr[31:25] == F7_MUL)
        |=> (!illegalOut && classOut[CLS_MULDIV]));

      p_narrow_r8: assert property (@(posedge clk) disable iff (!rstN)
        strobes.capture && ((instr[6:0] == OPC_IMM64) || (instr[6:0] == OPC_REG64))
        |=> illegalOut);

      p_upper_r9: assert property (@(posedge clk) disable iff (!rstN)
        strobes.capture && ((instr[6:0] == OPC_LUI) || (instr[6:0] == OPC_AUIPC))
        |=> (!illegalOut && classOut[CLS_UPPER]));

      p_valid_r11: assert property (@(posedge clk) disable iff (!rstN)
        strobes.capture |=> outValid);

      p_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
        !strobes.capture |=> (!outValid && $stable(classOut) && $stable(illegalOut)));
    end else begin : g_comb
      assign outValid   = strobes.capture;
      assign illegalOut = illegalComb;
      assign classOut   = classComb;
    end
  endgenerate

endmodule

// File: rtl/rvLegalityCheck.sv
module rvLegalityCheck
  import rvl_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [INSTR_W-1:0] instr,
  output logic               outValid,
  output logic               illegal,
  output logic [CLASS_W-1:0] instrClass
);

  rvlStrobes_t strobes;

  rvlControl u_ctrl (
    .opcode  (instr[OPC_W-1:0]),
    .inValid (inValid),
    .strobes (strobes)
  );

  rvlDatapath #(.REG_OUT(REG_OUT)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .instr      (instr),
    .strobes    (strobes),
    .outValid   (outValid),
    .illegalOut (illegal),
    .classOut   (instrClass)
  );

endmodule

// File: tb/rvLegalityCheck_test.sv
module rvLegalityCheck_test;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN;
  logic        inValid;
  logic [31:0] instr;
  logic        outValid;
  logic        illegal;
  logic [9:0]  instrClass;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  rvLegalityCheck uut (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .instr      (instr),
    .outValid   (outValid),
    .illegal    (illegal),
    .instrClass (instrClass)
  );

  function automatic logic [31:0] mk(logic [6:0] f7, logic [4:0] rs2, logic [4:0] rs1,
                                     logic [2:0] f3, logic [4:0] rd, logic [6:0] op);
    return {f7, rs2, rs1, f3, rd, op};
  endfunction

  // expected {illegal, class[9:0]} from the requirement text
  function automatic logic [10:0] refModel(logic [31:0] w);
    int op = int'(w[6:0]);
    int f3 = int'(w[14:12]);
    int f7 = int'(w[31:25]);
    int bitPos = -1;
    if (w[1:0] == 2'b11) begin
      case (op)
        'h03: if (f3 <= 5 && f3 != 3) bitPos = 0;
        'h23: if (f3 < 3) bitPos = 1;
        'h63: if (f3 != 2 && f3 != 3) bitPos = 2;
        'h6f: bitPos = 3;
        'h67: if (f3 == 0) bitPos = 3;
        'h13: begin
          if (f3 == 1)      begin if (f7 == 0) bitPos = 4; end
          else if (f3 == 5) begin if (f7 == 0 || f7 == 32) bitPos = 4; end
          else bitPos = 4;
        end
        'h33: begin
          if (f7 == 0) bitPos = 5;
          else if (f7 == 32 && (f3 == 0 || f3 == 5)) bitPos = 5;
          else if (f7 == 1) bitPos = 6;
        end
        'h37, 'h17: bitPos = 7;
        'h73: begin
          if (f3 == 0) begin
            if (w == 32'h0000_0073 || w == 32'h0010_0073) bitPos = 8;
          end else if (f3 != 4) bitPos = 8;
        end
        'h0f: if (f3 == 0) bitPos = 9;
        default: bitPos = -1;
      endcase
    end
    if (bitPos < 0) return 11'h400;
    return {1'b0, 10'(1 << bitPos)};
  endfunction

  function automatic string tagFor(logic [31:0] w);
    if (w[1:0] != 2'b11) return "R1";
    case (w[6:0])
      7'h03: return "R3";
      7'h23: return "R4";
      7'h13: return "R5";
      7'h33: return (w[31:25] == 7'd1) ? "R7" : "R6";
      7'h63, 7'h6f, 7'h67, 7'h37, 7'h17: return "R9";
      7'h73, 7'h0f: return "R10";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp, logic [31:0] w);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s word=%08h actual=%0h expected=%0h", tag, w, got, exp);
    end
  endtask

  // drive on a falling edge, sample one falling edge later (one capture edge between)
  task automatic apply(logic [31:0] w);
    logic [10:0] e;
    instr   = w;
    inValid = 1'b1;
    @(negedge clk);
    e = refModel(w);
    chk(tagFor(w), {31'd0, illegal}, {31'd0, e[10]}, w);
    chk("R2", {22'd0, instrClass}, {22'd0, e[9:0]}, w);
    chk("R11", {31'd0, outValid}, 32'd1, w);
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  logic [6:0] f7Set [6] = '{7'h00, 7'h01, 7'h20, 7'h21, 7'h40, 7'h7f};

  initial begin
    logic [9:0]  heldClass;
    logic        heldIllegal;
    rstN    = 1'b0;
    inValid = 1'b0;
    instr   = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", {31'd0, outValid}, 32'd0, 32'd0);
    chk("R11", {31'd0, illegal}, 32'd0, 32'd0);
    chk("R11", {22'd0, instrClass}, 32'd0, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // sweep every opcode, funct3 and a spread of funct7 values, random register fields
    for (int op = 0; op < 128; op++) begin
      for (int f3 = 0; f3 < 8; f3++) begin
        for (int k = 0; k < 7; k++) begin
          logic [6:0] f7;
          f7 = (k < 6) ? f7Set[k] : 7'($urandom);
          apply(mk(f7, 5'($urandom), 5'($urandom), 3'(f3), 5'($urandom), 7'(op)));
        end
      end
    end

    // targeted corner words
    apply(mk(7'h00, 5'd0, 5'd1, 3'b110, 5'd2, 7'h03));  // R3 unsigned word load
    apply(mk(7'h00, 5'd0, 5'd1, 3'b011, 5'd2, 7'h03));  // R3 doubleword load
    apply(mk(7'h00, 5'd3, 5'd1, 3'b011, 5'd0, 7'h23));  // R4 doubleword store
    apply(mk(7'h01, 5'd5, 5'd1, 3'b001, 5'd2, 7'h13));  // R5 SLLI shamt[5]
    apply(mk(7'h21, 5'd5, 5'd1, 3'b101, 5'd2, 7'h13));  // R5 SRAI shamt[5]
    apply(mk(7'h20, 5'd5, 5'd1, 3'b101, 5'd2, 7'h13));  // R5 SRAI legal
    apply(mk(7'h20, 5'd5, 5'd1, 3'b001, 5'd2, 7'h33));  // R6 alt funct7 with SLL
    for (int f3 = 0; f3 < 8; f3++)
      apply(mk(7'h01, 5'd3, 5'd4, 3'(f3), 5'd5, 7'h33)); // R7 all mul/div
    apply(mk(7'h00, 5'd1, 5'd1, 3'b000, 5'd1, 7'h3b));  // R8 word add
    apply(mk(7'h00, 5'd1, 5'd1, 3'b000, 5'd1, 7'h1b));  // R8 word add-immediate
    apply(32'h0000_0073);                                // R10 environment call
    apply(32'h0010_0073);                                // R10 breakpoint
    apply(32'h0020_0073);                                // R10 other funct3 000 word
    apply(mk(7'h18, 5'h00, 5'd1, 3'b001, 5'd2, 7'h73));  // R10 CSR access
    apply(mk(7'h00, 5'd0, 5'd0, 3'b001, 5'd0, 7'h0f));  // R10 fence funct3 001
    apply(32'h1234_5037);                                // R9 LUI
    apply(mk(7'h00, 5'd0, 5'd1, 3'b001, 5'd2, 7'h67));  // R9 JALR bad funct3

    // R11 hold: result stays while no word is offered
    apply(32'h1234_5037);
    heldClass   = instrClass;
    heldIllegal = illegal;
    inValid = 1'b0;
    instr   = 32'hffff_ffff;
    @(negedge clk);
    chk("R11", {31'd0, outValid}, 32'd0, instr);
    chk("R11", {22'd0, instrClass}, {22'd0, heldClass}, instr);
    chk("R11", {31'd0, illegal}, {31'd0, heldIllegal}, instr);
    @(negedge clk);
    chk("R11", {22'd0, instrClass}, {22'd0, heldClass}, instr);

    done = 1'b1;
    finishRun();
  end

endmodule